// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

A four-bit up counter whose state bits all update together on the rising clock edge. A parallel preset captures four data inputs on the next rising edge while the active-low load input is held low. An active-low clear returns the count to zero. The `ASYNC_CLR` parameter picks how the clear acts. When it is 1, the clear acts at once, with no clock edge. When it is 0, the clear takes effect at the next rising edge.

Two active-high enables gate counting: a parallel enable and a trickle enable. The trickle enable also qualifies the ripple carry output. The carry is high for the whole all-ones state whenever the trickle enable is high. To build a wider counter, several instances share the clock and the parallel enable, and each stage's carry drives the trickle enable of the next stage.

Each clock edge applies one operation, chosen by a small decoder. The operations are named CLEAR, LOAD, COUNT and HOLD. The decoder picks CLEAR when clear is low; otherwise LOAD when load is low; otherwise COUNT when both enables are high; otherwise HOLD.

Top module: `bincnt_top`

## Requirements
- R1: Apart from the immediate clear variant, the count output changes only at a rising clock edge; changing any other input between edges leaves it unchanged.
- R2: With `clr_n` high and `ld_n` low, the next rising edge copies `din` into `q`, whatever the enables are.
- R3: If `ld_n` goes low and returns high before a rising edge, that edge performs the normal count or hold, and no load happens.
- R4: With `ASYNC_CLR`=0, `q` becomes 0 at a rising edge where `clr_n` is low, and is unchanged before that edge.
- R5: With `ASYNC_CLR`=1, `q` becomes 0 as soon as `clr_n` falls, with no clock edge, and stays 0 while `clr_n` is low.
- R6: With `clr_n` and `ld_n` both high, `q` increments by one at the edge when `en_par` and `en_trk` are both 1; if either enable is 0, `q` holds.
- R7: `carry` is 0 whenever `en_trk` is 0; its value does not depend on `en_par`.
- R8: With `en_trk` at 1, `carry` is 1 for the whole time that `q` equals 15, and 0 for every other count.
- R9: Clear takes priority over load, load over count, and count over hold; counting wraps from 15 to 0.
- R10: `q[0]` is the least significant bit of the count, and `din[0]` loads into `q[0]`.
- R11: Two instances chained carry-to-trickle-enable, sharing the clock and the parallel enable, form an 8-bit counter that steps through 0 to 255 and wraps to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on its rising edge |
| clr_n | input | 1 | Active-low clear (acts at once or at the next edge, set by `ASYNC_CLR`) |
| ld_n | input | 1 | Active-low synchronous parallel load |
| din | input | WIDTH | Preset data, bit 0 least significant |
| en_par | input | 1 | Parallel count enable |
| en_trk | input | 1 | Trickle count enable, also gates `carry` |
| q | output | WIDTH | Count value, bit 0 least significant |
| carry | output | 1 | Ripple carry: high when `en_trk` is 1 and `q` is all ones |

## Verification
All sixteen preset values are loaded, and each is followed by the four combinations of the two enables. This shows whether count and hold depend on both enables or on only one of them. Because the loads happen with both enables low, a load that enables could block is exposed. Because the walk reaches 15, the carry is probed there, and so is the wrap from 15 to 0.

The clear is pulsed between clock edges while both variants hold the same value. This separates the immediate clear from the clear that waits for an edge. A clear and a load asserted together show which one wins. A load pulse that ends before the edge checks that the load is sampled only at the edge. The two-stage chain is run through all 256 counts, which tests the carry-to-trickle hand-off across the full range.

// File: rtl/bincnt_pkg.sv
package bincnt_pkg;
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_COUNT = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } op_e;
endpackage

// File: rtl/bincnt_ctl.sv
module bincnt_ctl
    import bincnt_pkg::*;
(
    input  logic clr_n,
    input  logic ld_n,
    input  logic en_par,
    input  logic en_trk,
    output op_e  op
);
    // Priority decode: clear, then load, then count, then hold.
    always_comb begin
        unique casez ({clr_n, ld_n, en_par & en_trk})
            3'b0??:  op = OP_CLEAR;
            3'b10?:  op = OP_LOAD;
            3'b111:  op = OP_COUNT;
            3'b110:  op = OP_HOLD;
            default: op = OP_HOLD;
        endcase
    end
endmodule

// File: rtl/bincnt_reg.sv
module bincnt_reg
    import bincnt_pkg::*;
#(
    parameter int WIDTH     = 4,
    parameter bit ASYNC_CLR = 1'b0
) (
    input  logic             clk,
    input  logic             clr_n,
    input  op_e              op,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q
);
    localparam logic [WIDTH-1:0] ZERO = '0;
    localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);

    logic [WIDTH-1:0] q_nxt;

    always_comb begin
        unique case (op)
            OP_CLEAR: q_nxt = ZERO;
            OP_LOAD:  q_nxt = din;
            OP_COUNT: q_nxt = q + ONE;
            OP_HOLD:  q_nxt = q;
            default:  q_nxt = q;
        endcase
    end

    generate
        if (ASYNC_CLR) begin : g_async_clr
            always_ff @(posedge clk or negedge clr_n) begin
                if (!clr_n) q <= ZERO;
                else        q <= q_nxt;
            end
        end else begin : g_sync_clr
            always_ff @(posedge clk) begin
                q <= q_nxt;
            end
        end
    endgenerate
endmodule

// File: rtl/bincnt_carry.sv
module bincnt_carry #(
    parameter int WIDTH = 4
) (
    input  logic             en_trk,
    input  logic [WIDTH-1:0] q,
    output logic             carry
);
    always_comb begin
        carry = en_trk & (&q);
    end
endmodule

// File: rtl/bincnt_top.sv
module bincnt_top
    import bincnt_pkg::*;
#(
    parameter int WIDTH     = 4,
    parameter bit ASYNC_CLR = 1'b0
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             ld_n,
    input  logic [WIDTH-1:0] din,
    input  logic             en_par,
    input  logic             en_trk,
    output logic [WIDTH-1:0] q,
    output logic             carry
);
    op_e op;

    bincnt_ctl ctl_i (
        .clr_n  (clr_n),
        .ld_n   (ld_n),
        .en_par (en_par),
        .en_trk (en_trk),
        .op     (op)
    );

    bincnt_reg #(.WIDTH(WIDTH), .ASYNC_CLR(ASYNC_CLR)) reg_i (
        .clk   (clk),
        .clr_n (clr_n),
        .op    (op),
        .din   (din),
        .q     (q)
    );

    bincnt_carry #(.WIDTH(WIDTH)) carry_i (
        .en_trk (en_trk),
        .q      (q),
        .carry  (carry)
    );
endmodule

// File: rtl/bincnt_chk.sv
module bincnt_chk #(
    parameter int WIDTH     = 4,
    parameter bit ASYNC_CLR = 1'b0
) (
    input logic             clk,
    input logic             clr_n,
    input logic             ld_n,
    input logic [WIDTH-1:0] din,
    input logic             en_par,
    input logic             en_trk,
    input logic [WIDTH-1:0] q,
    input logic             carry
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    // Set once a clear has been seen at an edge, so q is known from then on.
    logic armed = 1'b0;
    always_ff @(posedge clk) begin
        if (!clr_n) armed <= 1'b1;
    end

    a_r2_load: assert property (@(posedge clk) disable iff (!armed || !clr_n)
        ($past(clr_n) && !$past(ld_n)) |-> (q == $past(din)));

    a_r6_count: assert property (@(posedge clk) disable iff (!armed || !clr_n)
        ($past(clr_n) && $past(ld_n) && $past(en_par) && $past(en_trk))
        |-> (q == $past(q) + ONE));

    a_r6_hold: assert property (@(posedge clk) disable iff (!armed || !clr_n)
        ($past(clr_n) && $past(ld_n) && !($past(en_par) && $past(en_trk)))
        |-> $stable(q));

    a_r7_trk_gate: assert property (@(posedge clk) disable iff (!armed)
        !en_trk |-> !carry);

    a_r8_carry_ones: assert property (@(posedge clk) disable iff (!armed)
        carry |-> (&q));

    generate
        if (ASYNC_CLR) begin : g_async
            a_r5_async_clear: assert property (@(posedge clk) disable iff (!armed)
                !clr_n |-> (q == '0));
        end else begin : g_sync
            a_r4_sync_clear: assert property (@(posedge clk) disable iff (!armed)
                !$past(clr_n) |-> (q == '0));
        end
    endgenerate
endmodule

bind bincnt_top bincnt_chk #(.WIDTH(WIDTH), .ASYNC_CLR(ASYNC_CLR)) chk_i (
    .clk    (clk),
    .clr_n  (clr_n),
    .ld_n   (ld_n),
    .din    (din),
    .en_par (en_par),
    .en_trk (en_trk),
    .q      (q),
    .carry  (carry)
);

// File: tb/bincnt_top_tb_top.sv
module bincnt_top_tb_top;
    logic       clk = 1'b0;
    logic       clr_s, clr_a, ld_n, en_par, en_trk;
    logic [3:0] din;
    logic [3:0] q_s, q_a;
    logic       carry_s, carry_a;

    logic       clr_c, en_c;
    logic [3:0] q_lo, q_hi;
    logic       carry_lo, carry_hi;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    bincnt_top #(.WIDTH(4), .ASYNC_CLR(1'b0)) dut_i (
        .clk(clk), .clr_n(clr_s), .ld_n(ld_n), .din(din),
        .en_par(en_par), .en_trk(en_trk), .q(q_s), .carry(carry_s));

    bincnt_top #(.WIDTH(4), .ASYNC_CLR(1'b1)) dut_a (
        .clk(clk), .clr_n(clr_a), .ld_n(ld_n), .din(din),
        .en_par(en_par), .en_trk(en_trk), .q(q_a), .carry(carry_a));

    bincnt_top #(.WIDTH(4), .ASYNC_CLR(1'b0)) c_lo (
        .clk(clk), .clr_n(clr_c), .ld_n(1'b1), .din(4'd0),
        .en_par(en_c), .en_trk(1'b1), .q(q_lo), .carry(carry_lo));

    bincnt_top #(.WIDTH(4), .ASYNC_CLR(1'b0)) c_hi (
        .clk(clk), .clr_n(clr_c), .ld_n(1'b1), .din(4'd0),
        .en_par(en_c), .en_trk(carry_lo), .q(q_hi), .carry(carry_hi));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_q(input string req, input int exp);
        chk(int'(q_s) == exp, {req, " sync"},  int'(q_s), exp);
        chk(int'(q_a) == exp, {req, " async"}, int'(q_a), exp);
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int exp;
        clr_s = 1'b0; clr_a = 1'b0; ld_n = 1'b1; din = 4'd0;
        en_par = 1'b0; en_trk = 1'b1; clr_c = 1'b0; en_c = 1'b0;
        step();
        step();
        // Reset state
        chk_q("R4/R5 reset", 0);
        chk(carry_s == 1'b0, "R8 reset carry", int'(carry_s), 0);
        clr_s = 1'b1; clr_a = 1'b1;

        // Immediate vs edge clear (R4, R5)
        ld_n = 1'b0; din = 4'd9;
        step();
        ld_n = 1'b1;
        chk_q("R2 load 9", 9);
        #1; clr_s = 1'b0; clr_a = 1'b0; #1;
        chk(q_a == 4'd0, "R5 immediate clear", int'(q_a), 0);
        chk(q_s == 4'd9, "R4 no clear before edge", int'(q_s), 9);
        step();
        chk_q("R4/R5 cleared after edge", 0);
        en_par = 1'b1; en_trk = 1'b1;
        step();
        chk_q("R5 held while clear low", 0);
        clr_s = 1'b1; clr_a = 1'b1; en_par = 1'b0;

        // Bit order (R10)
        ld_n = 1'b0; din = 4'b0001;
        step();
        chk(q_s[0] == 1'b1 && q_s[3:1] == 3'd0, "R10 bit0 lsb", int'(q_s), 1);
        chk(q_a[0] == 1'b1 && q_a[3:1] == 3'd0, "R10 bit0 lsb async", int'(q_a), 1);
        exp = 1;

        // Sweep: every preset value, then every enable combination
        for (int v = 0; v < 16; v++) begin
            ld_n = 1'b0; din = 4'(v); en_par = 1'b0; en_trk = 1'b0;
            #1;
            chk_q("R1 no change between edges", exp);
            step();
            exp = v;
            chk_q("R2 load overrides disabled enables", exp);
            ld_n = 1'b1;
            for (int e = 0; e < 4; e++) begin
                en_par = e[0]; en_trk = e[1];
                #1;
                chk(carry_s == (en_trk && exp == 15), "R7/R8 carry",
                    int'(carry_s), int'(en_trk && exp == 15));
                chk(carry_a == (en_trk && exp == 15), "R7/R8 carry async",
                    int'(carry_a), int'(en_trk && exp == 15));
                step();
                if (e == 3) exp = (exp + 1) % 16;
                chk_q("R6 count/hold per enables", exp);
            end
        end

        // R7: carry independent of en_par
        ld_n = 1'b0; din = 4'd15; step(); ld_n = 1'b1;
        en_par = 1'b1; en_trk = 1'b0; #1;
        chk(carry_s == 1'b0, "R7 trickle low gates carry", int'(carry_s), 0);
        en_par = 1'b0; en_trk = 1'b1; #1;
        chk(carry_s == 1'b1, "R7 carry without parallel enable", int'(carry_s), 1);
        // R9 wrap
        en_par = 1'b1; step();
        chk_q("R9 wrap 15 to 0", 0);

        // R3: load pulse removed before edge
        ld_n = 1'b0; din = 4'd12; #1; ld_n = 1'b1;
        step();
        chk_q("R3 early load release counts", 1);

        // R9: clear beats load, load beats count
        ld_n = 1'b0; din = 4'd7; step();
        chk_q("R9 load beats count", 7);
        clr_s = 1'b0; ld_n = 1'b0; din = 4'd5; step();
        chk(q_s == 4'd0, "R9 clear beats load", int'(q_s), 0);
        clr_s = 1'b1; ld_n = 1'b1;

        // R11: two-stage cascade
        clr_c = 1'b0; step(); clr_c = 1'b1; en_c = 1'b1;
        for (int i = 0; i < 257; i++) begin
            chk(int'({q_hi, q_lo}) == (i % 256), "R11 cascade value",
                int'({q_hi, q_lo}), i % 256);
            chk(carry_hi == ((i % 256) == 255), "R11 cascade carry",
                int'(carry_hi), int'((i % 256) == 255));
            step();
        end
        finish_run();
    end
endmodule